// File: doc/BRIEF.md
# Serial Debug Memory-Read Sequencer

This block is the command engine behind a debug port. A host exchanges fixed-size frames with it over a full-duplex serial shift link. Each frame moves one 16-bit word from host to block and, at the same time, one reply from block to host. From these frames the block accepts a long-word read command and two address halves. It then runs one read on a request/acknowledge/error memory port and hands the 32-bit result back over the following frames.

Replies are pipelined. What a frame returns was decided before that frame began. It is always the outcome of earlier activity: not-ready while an address is being collected or a bus access is running, the result halves once the read is done, and distinct codes for a bus error and for an unknown command. A host that keeps shifting frames without pause is always served. The block never stalls the link.

Top module: `dbg_memrd_seq`

## Requirements
- R1: After reset, read_req is low and the reply waiting for the first frame is the command-complete code: flag bit 0, payload 0xFFFF, so the first bit shifted out is 0.
- R2: A frame is 17 shift_en pulses long, sent MSB first. Bit 16 is the status flag and bits 15:0 are the payload. dev_bit shows the next reply bit before each pulse. The last 16 bits received form the host word. A new frame may begin on the cycle right after the previous frame ends.
- R3: A command frame carrying opcode 0x1980 makes the next frame reply not-ready (flag 1, payload 0x0000). That next frame's word is taken as address bits 31:16.
- R4: A command frame carrying any other opcode makes the next frame reply illegal (flag 1, payload 0xFFFF). That frame's word is discarded. The block then waits for a new command, and the reply to that command frame is not-ready.
- R5: The frame carrying address bits 15:0 replies not-ready. read_req rises at the clock edge that ends this frame and never earlier. read_addr then equals the two address halves joined, with the upper half first.
- R6: read_req and read_addr stay unchanged until read_ack or read_err is seen. read_req is low on the following cycle.
- R7: A frame that begins while the bus access is outstanding replies not-ready, and its received word has no effect.
- R8: After read_ack, the next frame replies with flag 0 and read_data[31:16], and its word is decoded as a command. If that command is the read opcode, the frame after it replies with flag 0 and read_data[15:0] instead of not-ready.
- R9: If the command word received alongside the upper result half is not the read opcode, the illegal reply takes precedence and the lower result half is dropped.
- R10: After read_err, the next frame replies bus-error (flag 1, payload 0x0001), and its word is decoded as a new command. If read_ack and read_err are high together, the access counts as an error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| shift_en | input | 1 | One pulse per frame bit; shifts both directions |
| host_bit | input | 1 | Serial bit from host, sampled on a shift_en cycle |
| dev_bit | output | 1 | Serial reply bit to host, valid before each shift_en |
| read_req | output | 1 | Memory read request, held until completion |
| read_addr | output | 32 | Address of the requested long word |
| read_data | input | 32 | Read result, valid with read_ack |
| read_ack | input | 1 | Read finished successfully |
| read_err | input | 1 | Read finished with a bus error |

## Verification
The assertions assume that the memory side raises read_ack or read_err only while read_req is high, and for a single cycle per request. The bench memory model completes each request after a programmable latency with a one-cycle pulse and never responds unasked. They also assume that shift_en pulses arrive in whole frames, with no frame abandoned halfway. The bench drives every frame as exactly 17 pulses, either back to back or separated by idle gaps. It resets the block only between frames.

// File: rtl/dmr_pkg.sv
package dmr_pkg;

   typedef enum logic [2:0] {
      ST_CMD = 3'd0,
      ST_AHI = 3'd1,
      ST_ALO = 3'd2,
      ST_BUS = 3'd3,
      ST_RHI = 3'd4,
      ST_ILL = 3'd5
   } sq_state_t;

endpackage

// File: rtl/dmr_frame_shift.sv
module dmr_frame_shift #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_en,
   input  logic              host_bit,
   input  logic [DATA_W:0]   reply,
   output logic              dev_bit,
   output logic              frame_start,
   output logic              frame_done,
   output logic [DATA_W-1:0] rx_word
);
   localparam int FRAME_W = DATA_W + 1;
   localparam int CNT_W   = $clog2(FRAME_W + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

   logic [CNT_W-1:0]  cnt_q;
   logic [DATA_W:0]   tx_q;
   logic [DATA_W-1:0] rx_q;

   assign frame_start = shift_en && (cnt_q == '0);
   assign frame_done  = shift_en && (cnt_q == LAST);
   assign dev_bit     = (cnt_q == '0) ? reply[DATA_W] : tx_q[DATA_W];
   assign rx_word     = {rx_q[DATA_W-2:0], host_bit};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         tx_q  <= '0;
         rx_q  <= '0;
      end else if (shift_en) begin
         cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + CNT_W'(1);
         rx_q  <= {rx_q[DATA_W-2:0], host_bit};
         if (cnt_q == '0) tx_q <= {reply[DATA_W-1:0], 1'b0};
         else             tx_q <= {tx_q[DATA_W-1:0], 1'b0};
      end
   end

   // R2: the bit counter never leaves the frame
   p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST);
   // R2: a frame ends only after a run of pulses, never right after its start
   p_start_not_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |-> !frame_done);
endmodule

// File: rtl/dmr_bus_port.sv
module dmr_bus_port #(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic [ADDR_W-1:0] go_addr,
   input  logic              ack,
   input  logic              err,
   output logic              req,
   output logic [ADDR_W-1:0] addr
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req  <= 1'b0;
         addr <= '0;
      end else if (req && (ack || err)) begin
         req <= 1'b0;
      end else if (go) begin
         req  <= 1'b1;
         addr <= go_addr;
      end
   end

   // R6: request and address held until the memory answers
   p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !ack && !err) |=> (req && $stable(addr)));
   // R6: request withdrawn the cycle after completion
   p_req_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (req && (ack || err)) |=> !req);
endmodule

// File: rtl/dmr_cmd_seq.sv
module dmr_cmd_seq
   import dmr_pkg::*;
#(
   parameter int               DATA_W   = 16,
   parameter int               ADDR_W   = 32,
   parameter logic [DATA_W-1:0] READ_OP = 16'h1980,
   parameter bit               ERR_WINS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_start,
   input  logic              frame_done,
   input  logic [DATA_W-1:0] rx_word,
   input  logic              bus_req,
   input  logic              bus_ack,
   input  logic              bus_err,
   input  logic [ADDR_W-1:0] bus_rdata,
   output logic [DATA_W:0]   reply,
   output logic              rd_go,
   output logic [ADDR_W-1:0] rd_addr
);
   localparam int REPLY_W = DATA_W + 1;
   localparam logic [REPLY_W-1:0] NR_CODE   = {1'b1, {DATA_W{1'b0}}};
   localparam logic [REPLY_W-1:0] BERR_CODE = {1'b1, {(DATA_W-1){1'b0}}, 1'b1};
   localparam logic [REPLY_W-1:0] ILL_CODE  = {REPLY_W{1'b1}};
   localparam logic [REPLY_W-1:0] DONE_CODE = {1'b0, {DATA_W{1'b1}}};

   sq_state_t         state_q;
   logic [REPLY_W-1:0] reply_q;
   logic [DATA_W-1:0] addr_hi_q;
   logic [DATA_W-1:0] res_lo_q;
   logic              discard_q;
   logic              fin_ok, fin_bad;
   logic              accept, is_rd;

   generate
      if (ERR_WINS) begin : g_err_wins
         assign fin_bad = bus_err;
         assign fin_ok  = bus_ack & ~bus_err;
      end else begin : g_ack_wins
         assign fin_ok  = bus_ack;
         assign fin_bad = bus_err & ~bus_ack;
      end
   endgenerate

   assign accept  = frame_done && !discard_q;
   assign is_rd   = (rx_word == READ_OP);
   assign rd_go   = accept && (state_q == ST_ALO);
   assign rd_addr = {addr_hi_q, rx_word};
   assign reply   = reply_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ST_CMD;
         reply_q   <= DONE_CODE;
         addr_hi_q <= '0;
         res_lo_q  <= '0;
         discard_q <= 1'b0;
      end else begin
         if (frame_start) discard_q <= (state_q == ST_BUS);
         case (state_q)
            ST_BUS: begin
               if (fin_bad) begin
                  reply_q <= BERR_CODE;
                  state_q <= ST_CMD;
               end else if (fin_ok) begin
                  reply_q  <= {1'b0, bus_rdata[ADDR_W-1:DATA_W]};
                  res_lo_q <= bus_rdata[DATA_W-1:0];
                  state_q  <= ST_RHI;
               end
            end
            ST_CMD, ST_RHI: begin
               if (accept) begin
                  if (is_rd) begin
                     state_q <= ST_AHI;
                     reply_q <= (state_q == ST_RHI) ? {1'b0, res_lo_q} : NR_CODE;
                  end else begin
                     state_q <= ST_ILL;
                     reply_q <= ILL_CODE;
                  end
               end
            end
            ST_AHI: begin
               if (accept) begin
                  addr_hi_q <= rx_word;
                  reply_q   <= NR_CODE;
                  state_q   <= ST_ALO;
               end
            end
            ST_ALO: begin
               if (accept) begin
                  reply_q <= NR_CODE;
                  state_q <= ST_BUS;
               end
            end
            ST_ILL: begin
               if (accept) begin
                  reply_q <= NR_CODE;
                  state_q <= ST_CMD;
               end
            end
            default: state_q <= ST_CMD;
         endcase
      end
   end

   // R5: a request only rises after the low address frame was accepted
   p_req_after_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_req) |-> $past(rd_go));
   // R7: frames starting during the access see not-ready
   p_busy_reply_nr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_start && state_q == ST_BUS) |-> (reply_q == NR_CODE));
   // R5: the bus phase always runs with the request raised
   p_bus_has_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_BUS) |-> bus_req);
   // R4: the illegal state always offers the illegal code
   p_ill_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_ILL) |-> (reply_q == ILL_CODE));
   generate
      if (ERR_WINS) begin : g_err_chk
         // R10: an error completion yields the bus-error reply
         p_berr_reply_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (state_q == ST_BUS && bus_err) |=> (reply_q == BERR_CODE));
      end
   endgenerate
endmodule

// File: rtl/dbg_memrd_seq.sv
module dbg_memrd_seq #(
   parameter int               DATA_W   = 16,
   parameter int               ADDR_W   = 32,
   parameter logic [DATA_W-1:0] READ_OP = 16'h1980,
   parameter bit               ERR_WINS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_en,
   input  logic              host_bit,
   output logic              dev_bit,
   output logic              read_req,
   output logic [ADDR_W-1:0] read_addr,
   input  logic [ADDR_W-1:0] read_data,
   input  logic              read_ack,
   input  logic              read_err
);
   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("dbg_memrd_seq: DATA_W must be at least 2");
      end
      if (ADDR_W != 2 * DATA_W) begin : g_bad_addr
         $error("dbg_memrd_seq: ADDR_W must be twice DATA_W");
      end
   endgenerate

   logic [DATA_W:0]   reply;
   logic              frame_start, frame_done;
   logic [DATA_W-1:0] rx_word;
   logic              rd_go;
   logic [ADDR_W-1:0] rd_addr;

   dmr_frame_shift #(.DATA_W(DATA_W)) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .shift_en   (shift_en),
      .host_bit   (host_bit),
      .reply      (reply),
      .dev_bit    (dev_bit),
      .frame_start(frame_start),
      .frame_done (frame_done),
      .rx_word    (rx_word)
   );

   dmr_cmd_seq #(
      .DATA_W  (DATA_W),
      .ADDR_W  (ADDR_W),
      .READ_OP (READ_OP),
      .ERR_WINS(ERR_WINS)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .frame_start(frame_start),
      .frame_done (frame_done),
      .rx_word    (rx_word),
      .bus_req    (read_req),
      .bus_ack    (read_ack),
      .bus_err    (read_err),
      .bus_rdata  (read_data),
      .reply      (reply),
      .rd_go      (rd_go),
      .rd_addr    (rd_addr)
   );

   dmr_bus_port #(.ADDR_W(ADDR_W)) u_bus (
      .clk    (clk),
      .rst_n  (rst_n),
      .go     (rd_go),
      .go_addr(rd_addr),
      .ack    (read_ack),
      .err    (read_err),
      .req    (read_req),
      .addr   (read_addr)
   );
endmodule

// File: tb/sim_dbg_memrd_seq.sv
module sim_dbg_memrd_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        shift_en = 1'b0;
   logic        host_bit = 1'b0;
   logic        dev_bit;
   logic        read_req;
   logic [31:0] read_addr;
   logic [31:0] read_data = '0;
   logic        read_ack = 1'b0;
   logic        read_err = 1'b0;

   int checks = 0;
   int failures = 0;
   int mem_lat = 3;
   int mem_cnt = 0;

   always #10 clk = ~clk;

   dbg_memrd_seq u0 (
      .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .host_bit(host_bit),
      .dev_bit(dev_bit), .read_req(read_req), .read_addr(read_addr),
      .read_data(read_data), .read_ack(read_ack), .read_err(read_err)
   );

   function automatic logic [31:0] mem_val(input logic [31:0] a);
      return {~a[15:0], a[31:16]} ^ 32'hA5C3_0F96;
   endfunction

   // memory model: one-cycle completion pulse after mem_lat cycles; top nibble E -> error
   always @(posedge clk) begin
      if (!rst_n) begin
         read_ack <= 1'b0; read_err <= 1'b0; mem_cnt <= 0;
      end else if (read_ack || read_err) begin
         read_ack <= 1'b0; read_err <= 1'b0; mem_cnt <= 0;
      end else if (read_req) begin
         if (mem_cnt >= mem_lat) begin
            if (read_addr[31:28] == 4'hE) read_err <= 1'b1;
            else begin
               read_ack  <= 1'b1;
               read_data <= mem_val(read_addr);
            end
         end else mem_cnt <= mem_cnt + 1;
      end
   end

   function automatic string rname(input logic [3:0] n);
      case (n)
         4'd1: return "R1";  4'd2: return "R2";  4'd3: return "R3";
         4'd4: return "R4";  4'd5: return "R5";  4'd6: return "R6";
         4'd7: return "R7";  4'd8: return "R8";  4'd9: return "R9";
         default: return "R10";
      endcase
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic xfer(input logic [15:0] din, output logic [16:0] dout);
      logic [16:0] fr;
      fr = {1'b0, din};
      for (int i = 16; i >= 0; i--) begin
         @(negedge clk);
         dout[i]  = dev_bit;
         host_bit = fr[i];
         shift_en = 1'b1;
      end
   endtask

   task automatic idle(input int n);
      @(negedge clk);
      shift_en = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_bus;
      idle(1);
      while (read_req) @(negedge clk);
      @(negedge clk);
   endtask

   // {req tag, wait for bus, expected reply, host word}
   localparam int NV = 18;
   localparam logic [37:0] TBL [0:NV-1] = '{
      {4'd1,  1'b0, 17'h0FFFF, 16'h1980},
      {4'd3,  1'b0, 17'h10000, 16'h1234},
      {4'd5,  1'b1, 17'h10000, 16'h5678},
      {4'd8,  1'b0, 17'h00C44, 16'h1980},
      {4'd8,  1'b0, 17'h01DA2, 16'h0000},
      {4'd5,  1'b1, 17'h10000, 16'h0010},
      {4'd8,  1'b0, 17'h05A2C, 16'h2222},
      {4'd9,  1'b0, 17'h1FFFF, 16'hAAAA},
      {4'd4,  1'b0, 17'h10000, 16'h1980},
      {4'd3,  1'b0, 17'h10000, 16'hE000},
      {4'd5,  1'b1, 17'h10000, 16'h0004},
      {4'd10, 1'b0, 17'h10001, 16'h1981},
      {4'd4,  1'b0, 17'h1FFFF, 16'h0000},
      {4'd4,  1'b0, 17'h10000, 16'h1980},
      {4'd3,  1'b0, 17'h10000, 16'h0000},
      {4'd5,  1'b1, 17'h10000, 16'h0100},
      {4'd8,  1'b0, 17'h05B3C, 16'h1980},
      {4'd2,  1'b0, 17'h00F96, 16'h0000}
   };

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [16:0] r;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk("R1 read_req after reset", {31'd0, read_req}, 32'd0);
      chk("R1 first reply bit", {31'd0, dev_bit}, 32'd0);

      // vector walk, frames back to back unless waiting on the bus
      for (int k = 0; k < NV; k++) begin
         xfer(TBL[k][15:0], r);
         chk({rname(TBL[k][37:34]), " table reply"}, {15'd0, r}, {15'd0, TBL[k][32:16]});
         if (TBL[k][33]) wait_bus();
      end
      // state now: address high collected (0x0000), waiting for low half
      idle(0);
      chk("R5 no request before low address", {31'd0, read_req}, 32'd0);

      mem_lat = 40;
      xfer(16'h0030, r);
      chk("R5 low address reply", {15'd0, r}, {15'd0, 17'h10000});
      @(negedge clk);
      shift_en = 1'b0;
      chk("R5 request raised", {31'd0, read_req}, 32'd1);
      chk("R5 request address", read_addr, 32'h0000_0030);

      // R7: frame during the access
      xfer(16'h1980, r);
      chk("R7 reply during access", {15'd0, r}, {15'd0, 17'h10000});
      idle(0);
      chk("R6 address held", read_addr, 32'h0000_0030);
      while (!read_ack) @(negedge clk);
      @(negedge clk);
      chk("R6 request dropped after ack", {31'd0, read_req}, 32'd0);
      idle(1);
      mem_lat = 3;
      // discarded frame must not have started a command
      xfer(16'h2222, r);
      chk("R7 upper result after discarded frame", {15'd0, r}, {15'd0, 17'h05A0C});
      xfer(16'h0000, r);
      chk("R9 illegal after result", {15'd0, r}, {15'd0, 17'h1FFFF});

      // reset mid-sequence
      xfer(16'h1980, r);
      xfer(16'h4444, r);
      idle(1);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      xfer(16'h1980, r);
      chk("R1 reply after mid reset", {15'd0, r}, {15'd0, 17'h0FFFF});
      idle(2);
      chk("R1 no request after mid reset", {31'd0, read_req}, 32'd0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule